// File: doc/BRIEF.md
# Parallel Configuration Loader

This block acts as the external host that pushes a configuration image into a programmable device over an eight-bit parallel link. A one-cycle start request makes it hold the target's configuration-reset line low for a set number of system clocks. It then waits for the target's status line to fall and rise again. After that it reads image bytes from a simple asynchronous-read memory and presents them one per generated configuration clock period.

The target signals that it has all the data it needs by raising its configuration-complete input. This can happen one byte before the image is used up, and the block treats that as a normal finish. It then sends two more falling clock edges so the target can start initialising. Next it waits for the target's init-complete input to rise, within a watchdog window counted in system clocks. The outcome is reported as `done` or `error`. While idle or waiting, the configuration clock and data bus rest at a fixed level set by a parameter.

Top module: `cfg_parallel_loader`

## Requirements
- R1: A `start` pulse accepted in idle drives `cfgResetN` low for exactly PULSE_CYC system clocks, raises `busy` and clears `done` and `error`.
- R2: No rising edge appears on `cfgClk` until `tgtStatusN` has been seen low and then high after the reset pulse.
- R3: Byte i of the image is read from address `startAddr + i` and presented on `cfgData` for one `cfgClk` period, which is 2*DIV_HALF system clocks.
- R4: `cfgData` changes only while `cfgClk` is low, at least one system clock before the rising edge, and holds its value while `cfgClk` is high.
- R5: Once `tgtCfgDone` is seen high, no further image byte is driven: every later clock rise carries the idle pattern (all bits at IDLE_LEVEL). Completion one byte early counts as success, and so does completion on the last byte.
- R6: After `tgtCfgDone` is seen, exactly two further `cfgClk` falling edges are produced, and the clock then stops.
- R7: A low-to-high transition on `tgtInitDone` after those edges sets `done` (never together with `error`) and returns the block to idle.
- R8: If `tgtInitDone` does not rise within INIT_WAIT system clocks after the second extra falling edge, `error` is set and the block returns to idle.
- R9: In idle, `cfgClk` and every bit of `cfgData` (so also bit 0) rest at IDLE_LEVEL.
- R10: If `tgtStatusN` goes low while image bytes are being sent, the transfer stops at once, `error` is set and the block returns to idle.
- R11: If the whole image (`imageLen` bytes) is clocked out without `tgtCfgDone` rising, `error` is set. A start with `imageLen` of zero sets `error` at once and issues no reset pulse.
- R12: `start` is ignored while `busy` is high. No new reset pulse is issued and the running transfer is not disturbed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin loading |
| startAddr | input | ADDR_W | First image address, latched at start |
| imageLen | input | LEN_W | Image length in bytes, latched at start |
| memAddr | output | ADDR_W | Address of the byte being fetched |
| memData | input | 8 | Byte read asynchronously at memAddr |
| cfgResetN | output | 1 | Active-low configuration reset to the target |
| tgtStatusN | input | 1 | Target status, low while resetting or on error |
| cfgClk | output | 1 | Generated configuration clock |
| cfgData | output | 8 | Configuration byte bus |
| tgtCfgDone | input | 1 | Target reports it has received the image |
| tgtInitDone | input | 1 | Target reports it has entered user mode |
| busy | output | 1 | A load is in progress |
| done | output | 1 | Last load ended successfully |
| error | output | 1 | Last load failed |

## Verification
The assertions assume that the target inputs are already synchronous to `clk`. They also assume that a target raises `tgtCfgDone` no sooner than one system clock after a `cfgClk` rise, and that DIV_HALF is at least two, so that a data load never coincides with a clock rise. The bench target model samples `cfgClk` on the system clock and reacts one clock later, and it runs with DIV_HALF of three. This keeps every completion and abort response inside the high phase of the generated clock, so the stimulus stays within these assumptions. The image memory is a combinational array indexed by `memAddr`, which matches the asynchronous-read assumption on `memData`.

// File: rtl/cfgh_pkg.sv
package cfgh_pkg;
  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;   // latch start address and length
    logic clear;     // restart byte counter, clock low
    logic run;       // advance the clock divider
    logic sendData;  // low-phase load takes memory byte (else idle pattern)
    logic park;      // force clock and data to the idle level
  } dpCtl_t;

  typedef enum logic [2:0] {
    S_IDLE, S_PULSE, S_WLOW, S_WHIGH, S_SEND, S_FLUSH, S_WINIT
  } ldState_t;
endpackage

// File: rtl/cfgh_datapath.sv
module cfgh_datapath
  import cfgh_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LEN_W      = 16,
  parameter int DIV_HALF   = 2,
  parameter bit IDLE_LEVEL = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [LEN_W-1:0]  imageLen,
  input  logic [7:0]        memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              cfgClk,
  output logic [7:0]        cfgData,
  output logic              fallTick,
  output logic              lastFall
);
  localparam int DIV_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [7:0] IDLE_BYTE = {8{IDLE_LEVEL}};

  logic [DIV_W-1:0]  divCnt;
  logic              clkReg;
  logic [7:0]        dataReg;
  logic [LEN_W-1:0]  byteCnt;
  logic [LEN_W-1:0]  lenReg;
  logic [ADDR_W-1:0] baseAddr;
  logic              divEnd;

  assign divEnd = (divCnt == DIV_W'(DIV_HALF - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt   <= '0;
      clkReg   <= IDLE_LEVEL;
      dataReg  <= IDLE_BYTE;
      byteCnt  <= '0;
      lenReg   <= '0;
      baseAddr <= '0;
    end else begin
      if (ctl.capture) begin
        baseAddr <= startAddr;
        lenReg   <= imageLen;
      end
      if (ctl.park) begin
        clkReg  <= IDLE_LEVEL;
        dataReg <= IDLE_BYTE;
        divCnt  <= '0;
      end else if (ctl.clear) begin
        clkReg  <= 1'b0;
        dataReg <= IDLE_BYTE;
        divCnt  <= '0;
        byteCnt <= '0;
      end else if (ctl.run) begin
        if (divEnd) begin
          divCnt <= '0;
          clkReg <= !clkReg;
          if (clkReg) byteCnt <= byteCnt + 1'b1;
        end else begin
          divCnt <= divCnt + 1'b1;
        end
        // first cycle of the low phase: present the next byte
        if (!clkReg && divCnt == '0)
          dataReg <= ctl.sendData ? memData : IDLE_BYTE;
      end
    end
  end

  assign memAddr  = baseAddr + ADDR_W'(byteCnt);
  assign cfgClk   = clkReg;
  assign cfgData  = dataReg;
  assign fallTick = ctl.run && !ctl.park && !ctl.clear && clkReg && divEnd;
  assign lastFall = fallTick && (byteCnt == lenReg - 1'b1);

  // R4: data held while the generated clock is high during streaming
  p_hold_high_r4: assert property (@(posedge clk) disable iff (!rstN)
    (clkReg && $past(ctl.run)) |-> $stable(dataReg));
endmodule

// File: rtl/cfgh_control.sv
module cfgh_control
  import cfgh_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int PULSE_CYC = 16,
  parameter int INIT_WAIT = 8192
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LEN_W-1:0] imageLen,
  input  logic             tgtStatusN,
  input  logic             tgtCfgDone,
  input  logic             tgtInitDone,
  input  logic             fallTick,
  input  logic             lastFall,
  output dpCtl_t           ctl,
  output logic             cfgResetN,
  output logic             busy,
  output logic             done,
  output logic             error
);
  localparam int TMR_MAX = (PULSE_CYC > INIT_WAIT) ? PULSE_CYC : INIT_WAIT;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  ldState_t         state;
  logic [TMR_W-1:0] timer;
  logic             flushFalls;
  logic             initPrev;
  logic             resetReg;

  always_comb begin
    ctl          = '0;
    ctl.capture  = (state == S_IDLE) && start && (imageLen != '0);
    ctl.clear    = (state == S_WHIGH);
    ctl.run      = (state == S_SEND) || (state == S_FLUSH);
    ctl.sendData = (state == S_SEND);
    ctl.park     = (state == S_IDLE) || (state == S_PULSE) ||
                   (state == S_WLOW) || (state == S_WINIT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      timer      <= '0;
      flushFalls <= 1'b0;
      initPrev   <= 1'b0;
      resetReg   <= 1'b1;
      done       <= 1'b0;
      error      <= 1'b0;
    end else begin
      initPrev <= tgtInitDone;
      unique case (state)
        S_IDLE: if (start) begin
          done <= 1'b0;
          if (imageLen == '0) begin
            error <= 1'b1;
          end else begin
            error    <= 1'b0;
            timer    <= '0;
            resetReg <= 1'b0;
            state    <= S_PULSE;
          end
        end
        S_PULSE: begin
          timer <= timer + 1'b1;
          if (timer == TMR_W'(PULSE_CYC - 1)) begin
            resetReg <= 1'b1;
            state    <= S_WLOW;
          end
        end
        S_WLOW:  if (!tgtStatusN) state <= S_WHIGH;
        S_WHIGH: if (tgtStatusN) state <= S_SEND;
        S_SEND: begin
          if (!tgtStatusN) begin
            error <= 1'b1;
            state <= S_IDLE;
          end else if (tgtCfgDone) begin
            flushFalls <= 1'b0;
            state      <= S_FLUSH;
          end else if (lastFall) begin
            error <= 1'b1;
            state <= S_IDLE;
          end
        end
        S_FLUSH: if (fallTick) begin
          flushFalls <= 1'b1;
          if (flushFalls) begin
            timer <= '0;
            state <= S_WINIT;
          end
        end
        S_WINIT: begin
          timer <= timer + 1'b1;
          if (tgtInitDone && !initPrev) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else if (timer == TMR_W'(INIT_WAIT - 1)) begin
            error <= 1'b1;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cfgResetN = resetReg;
  assign busy      = (state != S_IDLE);

  // R2: streaming is entered only with the status line released
  p_send_entry_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_SEND && $past(state) != S_SEND) |-> $past(tgtStatusN));
  // R6: the wait for init begins right on a generated falling edge
  p_flush_exit_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WINIT && $past(state) == S_FLUSH) |-> $past(fallTick));
  // R7: success and failure never reported together
  p_outcome_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({done, error}));
  // R1: the reset pulse only occurs inside a load
  p_pulse_busy_r1: assert property (@(posedge clk) disable iff (!rstN)
    !cfgResetN |-> busy);
endmodule

// File: rtl/cfg_parallel_loader.sv
module cfg_parallel_loader
  import cfgh_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LEN_W      = 16,
  parameter int DIV_HALF   = 2,
  parameter int PULSE_CYC  = 16,
  parameter int INIT_WAIT  = 8192,
  parameter bit IDLE_LEVEL = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [LEN_W-1:0]  imageLen,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memData,
  output logic              cfgResetN,
  input  logic              tgtStatusN,
  output logic              cfgClk,
  output logic [7:0]        cfgData,
  input  logic              tgtCfgDone,
  input  logic              tgtInitDone,
  output logic              busy,
  output logic              done,
  output logic              error
);
  dpCtl_t ctl;
  logic   fallTick;
  logic   lastFall;

  cfgh_control #(
    .LEN_W(LEN_W), .PULSE_CYC(PULSE_CYC), .INIT_WAIT(INIT_WAIT)
  ) uCtl (
    .clk(clk), .rstN(rstN), .start(start), .imageLen(imageLen),
    .tgtStatusN(tgtStatusN), .tgtCfgDone(tgtCfgDone), .tgtInitDone(tgtInitDone),
    .fallTick(fallTick), .lastFall(lastFall), .ctl(ctl),
    .cfgResetN(cfgResetN), .busy(busy), .done(done), .error(error)
  );

  cfgh_datapath #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DIV_HALF(DIV_HALF), .IDLE_LEVEL(IDLE_LEVEL)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .startAddr(startAddr), .imageLen(imageLen),
    .memData(memData), .memAddr(memAddr), .cfgClk(cfgClk), .cfgData(cfgData),
    .fallTick(fallTick), .lastFall(lastFall)
  );

  // R9: settled idle keeps clock and data bit 0 at the rest level
  p_park_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy)) |-> (cfgClk == IDLE_LEVEL && cfgData[0] == IDLE_LEVEL));
endmodule

// File: tb/sim_cfg_parallel_loader.sv
module sim_cfg_parallel_loader;
  localparam int CLK_P     = 10;
  localparam int DIV_HALF  = 3;
  localparam int PULSE_CYC = 5;
  localparam int INIT_WAIT = 4000;
  localparam int STAT_DLY  = 4;
  localparam bit IDLE      = 1'b1;

  logic       clk = 0, rstN = 0, start = 0;
  logic [7:0] startAddr = 0, imageLen = 0, memAddr, memData, cfgData;
  logic       cfgResetN, cfgClk, busy, done, error;
  logic       tgtStatusN = 1, tgtCfgDone = 0, tgtInitDone = 0;
  logic [7:0] mem [256];
  logic [7:0] rx [256];

  int nChecks = 0, nFail = 0, cyc = 0;
  int doneAt = 0, dropAt = 0, initDelay = 0;
  logic capEn = 0;
  int rxCnt = 0, earlyRise = 0, perViol = 0, holdViol = 0, flushBad = 0;
  int fallAfter = 0, initCnt = 0, lastRise = 0, lowRun = 0, lastLow = 0;
  int pulseCnt = 0, flushEndCyc = 0, stCnt = 0;
  logic dropped = 0, prevClk = 1, prevRstN = 1;
  logic [7:0] prevData = 8'hFF;

  always #(CLK_P/2) clk = ~clk;
  assign memData = mem[memAddr];

  cfg_parallel_loader #(
    .ADDR_W(8), .LEN_W(8), .DIV_HALF(DIV_HALF), .PULSE_CYC(PULSE_CYC),
    .INIT_WAIT(INIT_WAIT), .IDLE_LEVEL(IDLE)
  ) u0 (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr), .imageLen(imageLen),
    .memAddr(memAddr), .memData(memData), .cfgResetN(cfgResetN), .tgtStatusN(tgtStatusN),
    .cfgClk(cfgClk), .cfgData(cfgData), .tgtCfgDone(tgtCfgDone), .tgtInitDone(tgtInitDone),
    .busy(busy), .done(done), .error(error)
  );

  // behavioural target, sampled on the system clock
  always @(posedge clk) begin
    cyc      <= cyc + 1;
    prevClk  <= cfgClk;
    prevData <= cfgData;
    prevRstN <= cfgResetN;
    if (!cfgResetN) lowRun <= lowRun + 1;
    else if (lowRun != 0) begin lastLow <= lowRun; lowRun <= 0; end
    if (prevRstN && !cfgResetN) pulseCnt <= pulseCnt + 1;
    if (capEn && cfgClk != prevClk && cfgData != prevData) holdViol <= holdViol + 1;
    if (!cfgResetN) begin
      tgtStatusN <= 0; stCnt <= 0; dropped <= 0; tgtCfgDone <= 0;
      tgtInitDone <= 0; fallAfter <= 0; initCnt <= 0;
    end else begin
      if (!tgtStatusN && !dropped) begin
        stCnt <= stCnt + 1;
        if (stCnt == STAT_DLY) tgtStatusN <= 1;
      end
      if (cfgClk && !prevClk && capEn) begin
        if (!tgtStatusN) earlyRise <= earlyRise + 1;
        else if (tgtCfgDone) begin
          if (cfgData != {8{IDLE}}) flushBad <= flushBad + 1;
        end else begin
          rx[rxCnt[7:0]] <= cfgData;
          rxCnt <= rxCnt + 1;
          if (rxCnt > 0 && cyc - lastRise != 2*DIV_HALF) perViol <= perViol + 1;
          lastRise <= cyc;
          if (rxCnt + 1 == doneAt) tgtCfgDone <= 1;
          if (rxCnt + 1 == dropAt) begin tgtStatusN <= 0; dropped <= 1; end
        end
      end
      if (!cfgClk && prevClk && tgtCfgDone) begin
        fallAfter <= fallAfter + 1;
        if (fallAfter == 1) flushEndCyc <= cyc;
      end
      if (tgtCfgDone && fallAfter >= 2 && initDelay != 0 && !tgtInitDone) begin
        initCnt <= initCnt + 1;
        if (initCnt + 1 == initDelay) tgtInitDone <= 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitIdle();
    int n = 0;
    @(negedge clk);
    while (busy && n < 20000) begin @(negedge clk); n++; end
    check(!busy, "R7 load finishes", busy, 0);
  endtask

  task automatic kick(input int sa, input int len);
    @(negedge clk);
    startAddr = 8'(sa); imageLen = 8'(len); start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic setup(input int dAt, input int drop, input int iDly);
    doneAt = dAt; dropAt = drop; initDelay = iDly;
    rxCnt = 0; earlyRise = 0; perViol = 0; holdViol = 0; flushBad = 0;
    capEn = 1;
  endtask

  function automatic int byteMismatch(input int sa);
    int m = 0;
    for (int i = 0; i < rxCnt; i++) if (rx[i] != mem[8'(sa + i)]) m++;
    return m;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    check(!busy && !done && !error, "R9 reset outputs quiet", {busy, done, error}, 0);
    check(cfgResetN == 1, "R9 reset line released", cfgResetN, 1);
    check(cfgClk == IDLE && cfgData == {8{IDLE}}, "R9 reset rest level", {cfgClk, cfgData}, {IDLE, {8{IDLE}}});
  endtask

  task automatic t_early();
    setup(19, 0, 200);
    kick(10, 20);
    waitIdle(); capEn = 0;
    check(lastLow == PULSE_CYC, "R1 reset pulse width", lastLow, PULSE_CYC);
    check(earlyRise == 0, "R2 no clock before status", earlyRise, 0);
    check(rxCnt == 19, "R5 early completion byte count", rxCnt, 19);
    check(byteMismatch(10) == 0, "R3 byte order and address", byteMismatch(10), 0);
    check(perViol == 0, "R3 clock period", perViol, 0);
    check(holdViol == 0, "R4 data hold across edges", holdViol, 0);
    check(flushBad == 0, "R5 idle pattern after completion", flushBad, 0);
    check(fallAfter == 2, "R6 extra falling edges", fallAfter, 2);
    check(done && !error, "R7 success reported", {done, error}, 2);
    repeat (2) @(negedge clk);
    check(cfgClk == IDLE && cfgData[0] == IDLE, "R9 parked after load", {cfgClk, cfgData[0]}, {IDLE, IDLE});
  endtask

  task automatic t_full();
    setup(12, 0, 50);
    kick(100, 12);
    waitIdle(); capEn = 0;
    check(rxCnt == 12, "R5 completion on final byte", rxCnt, 12);
    check(byteMismatch(100) == 0, "R3 second image contents", byteMismatch(100), 0);
    check(done && !error, "R5 full-length success", {done, error}, 2);
    check(fallAfter == 2, "R6 edges after full image", fallAfter, 2);
  endtask

  task automatic t_timeout();
    int dt;
    setup(6, 0, 0);
    kick(3, 7);
    waitIdle(); capEn = 0;
    dt = cyc - flushEndCyc;
    check(error && !done, "R8 init timeout error", {done, error}, 1);
    check(dt >= INIT_WAIT - 3 && dt <= INIT_WAIT + 4, "R8 watchdog window", dt, INIT_WAIT);
  endtask

  task automatic t_abort();
    setup(0, 5, 50);
    kick(40, 20);
    waitIdle(); capEn = 0;
    check(error && !done, "R10 status drop error", {done, error}, 1);
    check(rxCnt == 5, "R10 transfer stopped", rxCnt, 5);
    repeat (2) @(negedge clk);
    check(cfgClk == IDLE && cfgData[0] == IDLE, "R9 parked after abort", {cfgClk, cfgData[0]}, {IDLE, IDLE});
  endtask

  task automatic t_exhaust();
    setup(0, 0, 50);
    kick(200, 8);
    waitIdle(); capEn = 0;
    check(error && !done, "R11 image exhausted error", {done, error}, 1);
    check(rxCnt == 8, "R11 all bytes sent", rxCnt, 8);
  endtask

  task automatic t_zero();
    int p0 = pulseCnt;
    kick(0, 0);
    @(negedge clk);
    check(error && !busy, "R11 zero length rejected", {busy, error}, 1);
    check(pulseCnt == p0, "R11 no reset pulse for zero length", pulseCnt - p0, 0);
  endtask

  task automatic t_busyStart();
    int p0 = pulseCnt;
    int n = 0;
    setup(15, 0, 30);
    kick(60, 16);
    while (rxCnt < 4 && n < 2000) begin @(negedge clk); n++; end
    startAddr = 8'd0; imageLen = 8'd3; start = 1;
    @(negedge clk); start = 0;
    waitIdle(); capEn = 0;
    check(pulseCnt == p0 + 1, "R12 no second reset pulse", pulseCnt - p0, 1);
    check(rxCnt == 15 && byteMismatch(60) == 0, "R12 transfer undisturbed", rxCnt, 15);
    check(done && !error, "R12 run completes", {done, error}, 2);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    repeat (3) @(negedge clk);
    rstN = 1;
    t_reset();
    t_early();
    t_full();
    t_timeout();
    t_abort();
    t_exhaust();
    t_zero();
    t_busyStart();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule